// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts each 32-bit virtual address into one of five fixed regions of the address space: the user region, two unmapped kernel windows and two mapped kernel regions. An address in an unmapped window is turned into a physical address directly, one cycle after the request. An address in a mapped region is passed to an external page-table lookup unit. The block then waits for that unit's verdict and turns it into either a physical address or a fault.

When an access cannot complete, the block reports a fault. The report holds an exception code, the faulting virtual address, and new values for the page-table context register and the translation-key register, built from the faulting address and the current contents of those registers. Only one request is handled at a time. While a lookup is outstanding, new requests are dropped. A separate error-level status input turns off translation of the user region, so the user region maps one-to-one.

Top module: `vseg_xlate`

## Requirements
- R1: After reset, `respValid`, `faultStrobe` and `tlbReq` are all low.
- R2: A request with `userMode` high and `vaddr[31]` set gives `faultStrobe` in the next cycle. The exception code is 4 for a read and 5 for a write, and no lookup is issued.
- R3: A user-region address (`vaddr[31]` clear) with `erlSet` low issues a one-cycle `tlbReq` in the next cycle, carrying the address on `tlbVaddr` and the access kind on `tlbWrite`. With `erlSet` high, the same address instead gives `respValid` with `paddr` equal to `vaddr`, in user or kernel mode.
- R4: In kernel mode, an address in 0x80000000..0x9FFFFFFF gives `respValid` in the next cycle with `paddr = vaddr - 0x80000000`.
- R5: In kernel mode, an address in 0xA0000000..0xBFFFFFFF gives `respValid` in the next cycle with `paddr = vaddr - 0xA0000000`.
- R6: In kernel mode, an address at or above 0xC0000000 issues a lookup in the same way as R3.
- R7: A lookup verdict is taken in the cycle where `tlbValid` is high, with `tlbStatus` coded 0 = hit, 1 = no entry, 2 = entry not valid, 3 = entry not writable. On a hit, the next cycle has `respValid` with `paddr = tlbPaddr`.
- R8: Verdicts 1 and 2 give a fault with exception code 2 for a read and 3 for a write. `refill` is high only for verdict 1.
- R9: Verdict 3 gives a fault with exception code 1 and `refill` low.
- R10: On every fault, `badVaddr` is the request address and `ctxOut` is `{ctxHiIn, vaddr[31:13], 4'b0000}`. `entryHiOut` is `{vaddr[31:13], 5'b00000, asidIn}`. `ctxHiIn` and `asidIn` are sampled with the request.
- R11: `respValid` and `faultStrobe` last one cycle each and are never high together. A request made while a lookup is outstanding is ignored, and so is a `tlbValid` that arrives when no lookup is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| vaddr | input | 32 | Virtual address |
| isWrite | input | 1 | 1 = store access |
| userMode | input | 1 | Requester runs in user mode |
| erlSet | input | 1 | Error-level status; disables user-region translation |
| ctxHiIn | input | 9 | Preserved upper field of the context register |
| asidIn | input | 8 | Current address-space identifier |
| tlbValid | input | 1 | Lookup verdict strobe |
| tlbStatus | input | 2 | Lookup verdict code |
| tlbPaddr | input | 32 | Physical address on a hit |
| tlbReq | output | 1 | Lookup request pulse |
| tlbVaddr | output | 32 | Address to look up |
| tlbWrite | output | 1 | Lookup is for a store |
| respValid | output | 1 | Translation done pulse |
| paddr | output | 32 | Physical address |
| faultStrobe | output | 1 | Fault report pulse |
| excCode | output | 5 | Exception code |
| refill | output | 1 | Fault came from a missing entry |
| badVaddr | output | 32 | Faulting virtual address |
| ctxOut | output | 32 | Updated context register value |
| entryHiOut | output | 32 | Updated translation-key register value |

## Verification
Requests are aimed at each region, including the first and last address of each unmapped window. This exposes off-by-one decoding of the top three address bits and wrong offset subtraction. Each lookup verdict is tried with both reads and writes, which separates the five exception codes and shows that only a missing entry raises `refill`. A context value of all ones and a nonzero identifier show whether the register updates keep the right bits. Stray requests and stray verdicts are sent at the wrong time to show that they leave no trace on the outputs.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  localparam int ADDR_W = 32;
  localparam int EXC_W = 5;
  localparam int CTX_FIELD_LSB = 4;

  typedef enum logic [1:0] {
    TLB_HIT   = 2'd0,
    TLB_MISS  = 2'd1,
    TLB_INVAL = 2'd2,
    TLB_DIRTY = 2'd3
  } tlbStat_e;

  typedef enum logic [1:0] {
    CLS_DIRECT = 2'd0,
    CLS_MAPPED = 2'd1,
    CLS_BAD    = 2'd2
  } reqCls_e;

  typedef struct packed {
    logic capture;
    logic sendTlb;
    logic finDirect;
    logic finBad;
    logic finTlb;
  } ctlStrb_t;

  localparam logic [EXC_W-1:0] EXC_MOD  = 5'd1;
  localparam logic [EXC_W-1:0] EXC_TLBL = 5'd2;
  localparam logic [EXC_W-1:0] EXC_TLBS = 5'd3;
  localparam logic [EXC_W-1:0] EXC_ADEL = 5'd4;
  localparam logic [EXC_W-1:0] EXC_ADES = 5'd5;
endpackage

// File: rtl/vseg_ctrl.sv
module vseg_ctrl
  import vseg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  reqCls_e  reqCls,
  input  logic     tlbValid,
  output ctlStrb_t strb
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e stQ, stD;

  always_comb begin
    strb = '0;
    stD  = stQ;
    unique case (stQ)
      ST_IDLE: begin
        if (reqValid) begin
          strb.capture = 1'b1;
          unique case (reqCls)
            CLS_DIRECT: strb.finDirect = 1'b1;
            CLS_BAD:    strb.finBad = 1'b1;
            default: begin
              strb.sendTlb = 1'b1;
              stD = ST_WAIT;
            end
          endcase
        end
      end
      default: begin
        if (tlbValid) begin
          strb.finTlb = 1'b1;
          stD = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stD;
  end
endmodule

// File: rtl/vseg_datapath.sv
module vseg_datapath
  import vseg_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int ASID_W = 8,
  localparam int VPN2_LSB = PAGE_SHIFT + 1,
  localparam int VPN2_W = ADDR_W - VPN2_LSB,
  localparam int CTX_KEEP_LSB = CTX_FIELD_LSB + VPN2_W,
  localparam int CTX_HI_W = ADDR_W - CTX_KEEP_LSB
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrb_t            strb,
  input  logic [ADDR_W-1:0]   vaddr,
  input  logic                isWrite,
  input  logic                userMode,
  input  logic                erlSet,
  input  logic [CTX_HI_W-1:0] ctxHiIn,
  input  logic [ASID_W-1:0]   asidIn,
  input  logic [1:0]          tlbStatus,
  input  logic [ADDR_W-1:0]   tlbPaddr,
  output reqCls_e             reqCls,
  output logic                tlbReq,
  output logic [ADDR_W-1:0]   tlbVaddr,
  output logic                tlbWrite,
  output logic                respValid,
  output logic [ADDR_W-1:0]   paddr,
  output logic                faultStrobe,
  output logic [EXC_W-1:0]    excCode,
  output logic                refill,
  output logic [ADDR_W-1:0]   badVaddr,
  output logic [ADDR_W-1:0]   ctxOut,
  output logic [ADDR_W-1:0]   entryHiOut
);
  // region decode from the top three address bits
  logic [2:0] segSel;
  logic [ADDR_W-1:0] directPa;
  assign segSel = vaddr[ADDR_W-1 -: 3];

  always_comb begin
    if (userMode && segSel[2])       reqCls = CLS_BAD;
    else if (!segSel[2])             reqCls = erlSet ? CLS_DIRECT : CLS_MAPPED;
    else if (segSel[1:0] == 2'b00 ||
             segSel[1:0] == 2'b01)   reqCls = CLS_DIRECT;
    else                             reqCls = CLS_MAPPED;
  end

  // both unmapped kernel windows strip the top three bits
  assign directPa = segSel[2] ? {3'b000, vaddr[ADDR_W-4:0]} : vaddr;

  // request context held across a lookup
  logic [ADDR_W-1:0]   addrQ;
  logic                writeQ;
  logic [CTX_HI_W-1:0] ctxQ;
  logic [ASID_W-1:0]   asidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      ctxQ   <= '0;
      asidQ  <= '0;
    end else if (strb.capture) begin
      addrQ  <= vaddr;
      writeQ <= isWrite;
      ctxQ   <= ctxHiIn;
      asidQ  <= asidIn;
    end
  end

  // fault source: live inputs for an address error, held copy after a lookup
  logic [ADDR_W-1:0]   srcAddr;
  logic                srcWrite;
  logic [CTX_HI_W-1:0] srcCtx;
  logic [ASID_W-1:0]   srcAsid;
  tlbStat_e            verdict;
  logic                faultNext;
  logic                refillNext;
  logic [EXC_W-1:0]    excNext;

  assign srcAddr  = strb.finTlb ? addrQ  : vaddr;
  assign srcWrite = strb.finTlb ? writeQ : isWrite;
  assign srcCtx   = strb.finTlb ? ctxQ   : ctxHiIn;
  assign srcAsid  = strb.finTlb ? asidQ  : asidIn;
  assign verdict  = tlbStat_e'(tlbStatus);

  always_comb begin
    faultNext  = 1'b0;
    refillNext = 1'b0;
    excNext    = '0;
    if (strb.finBad) begin
      faultNext = 1'b1;
      excNext   = srcWrite ? EXC_ADES : EXC_ADEL;
    end else if (strb.finTlb) begin
      unique case (verdict)
        TLB_HIT: faultNext = 1'b0;
        TLB_MISS: begin
          faultNext  = 1'b1;
          refillNext = 1'b1;
          excNext    = srcWrite ? EXC_TLBS : EXC_TLBL;
        end
        TLB_INVAL: begin
          faultNext = 1'b1;
          excNext   = srcWrite ? EXC_TLBS : EXC_TLBL;
        end
        default: begin
          faultNext = 1'b1;
          excNext   = EXC_MOD;
        end
      endcase
    end
  end

  logic [ADDR_W-1:0] ctxNext;
  logic [ADDR_W-1:0] ehNext;
  assign ctxNext = {srcCtx, srcAddr[ADDR_W-1:VPN2_LSB], {CTX_FIELD_LSB{1'b0}}};
  assign ehNext  = {srcAddr[ADDR_W-1:VPN2_LSB], {(VPN2_LSB-ASID_W){1'b0}}, srcAsid};

  logic hitNext;
  assign hitNext = strb.finTlb && (verdict == TLB_HIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tlbReq      <= 1'b0;
      tlbVaddr    <= '0;
      tlbWrite    <= 1'b0;
      respValid   <= 1'b0;
      paddr       <= '0;
      faultStrobe <= 1'b0;
      excCode     <= '0;
      refill      <= 1'b0;
      badVaddr    <= '0;
      ctxOut      <= '0;
      entryHiOut  <= '0;
    end else begin
      tlbReq      <= strb.sendTlb;
      respValid   <= strb.finDirect | hitNext;
      faultStrobe <= faultNext;
      if (strb.sendTlb) begin
        tlbVaddr <= vaddr;
        tlbWrite <= isWrite;
      end
      if (strb.finDirect) paddr <= directPa;
      else if (hitNext)   paddr <= tlbPaddr;
      if (faultNext) begin
        excCode    <= excNext;
        refill     <= refillNext;
        badVaddr   <= srcAddr;
        ctxOut     <= ctxNext;
        entryHiOut <= ehNext;
      end
    end
  end
endmodule

// File: rtl/vseg_xlate.sv
module vseg_xlate
  import vseg_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int ASID_W = 8,
  localparam int CTX_HI_W = PAGE_SHIFT - 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [31:0]         vaddr,
  input  logic                isWrite,
  input  logic                userMode,
  input  logic                erlSet,
  input  logic [CTX_HI_W-1:0] ctxHiIn,
  input  logic [ASID_W-1:0]   asidIn,
  input  logic                tlbValid,
  input  logic [1:0]          tlbStatus,
  input  logic [31:0]         tlbPaddr,
  output logic                tlbReq,
  output logic [31:0]         tlbVaddr,
  output logic                tlbWrite,
  output logic                respValid,
  output logic [31:0]         paddr,
  output logic                faultStrobe,
  output logic [4:0]          excCode,
  output logic                refill,
  output logic [31:0]         badVaddr,
  output logic [31:0]         ctxOut,
  output logic [31:0]         entryHiOut
);
  ctlStrb_t strb;
  reqCls_e  reqCls;

  vseg_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqCls(reqCls), .tlbValid(tlbValid), .strb(strb)
  );

  vseg_datapath #(.PAGE_SHIFT(PAGE_SHIFT), .ASID_W(ASID_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .vaddr(vaddr), .isWrite(isWrite),
    .userMode(userMode), .erlSet(erlSet), .ctxHiIn(ctxHiIn), .asidIn(asidIn),
    .tlbStatus(tlbStatus), .tlbPaddr(tlbPaddr), .reqCls(reqCls),
    .tlbReq(tlbReq), .tlbVaddr(tlbVaddr), .tlbWrite(tlbWrite),
    .respValid(respValid), .paddr(paddr), .faultStrobe(faultStrobe),
    .excCode(excCode), .refill(refill), .badVaddr(badVaddr),
    .ctxOut(ctxOut), .entryHiOut(entryHiOut)
  );
endmodule

// File: rtl/vseg_xlate_chk.sv
module vseg_xlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] vaddr,
  input logic        isWrite,
  input logic        userMode,
  input logic        erlSet,
  input logic [8:0]  ctxHiIn,
  input logic [7:0]  asidIn,
  input logic        tlbValid,
  input logic [1:0]  tlbStatus,
  input logic [31:0] tlbPaddr,
  input logic        tlbReq,
  input logic [31:0] tlbVaddr,
  input logic        tlbWrite,
  input logic        respValid,
  input logic [31:0] paddr,
  input logic        faultStrobe,
  input logic [4:0]  excCode,
  input logic        refill,
  input logic [31:0] badVaddr,
  input logic [31:0] ctxOut,
  input logic [31:0] entryHiOut
);
  // lookup outstanding, tracked from the ports only
  logic pendQ;
  logic busy;
  assign busy = tlbReq | pendQ;
  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= busy & ~tlbValid;
  end

  logic idleReq;
  assign idleReq = reqValid && !busy;

  p_bad_user_r2: assert property (@(posedge clk) disable iff (!rstN)
    idleReq && userMode && vaddr[31] |=> faultStrobe && !tlbReq &&
      excCode == ($past(isWrite) ? 5'd5 : 5'd4) &&
      ctxOut[31:23] == $past(ctxHiIn));

  p_useg_lookup_r3: assert property (@(posedge clk) disable iff (!rstN)
    idleReq && !erlSet && !vaddr[31] |=> tlbReq &&
      tlbVaddr == $past(vaddr) && tlbWrite == $past(isWrite));

  p_useg_erl_r3: assert property (@(posedge clk) disable iff (!rstN)
    idleReq && erlSet && !vaddr[31] |=> respValid && paddr == $past(vaddr));

  p_kseg1_r5: assert property (@(posedge clk) disable iff (!rstN)
    idleReq && !userMode && vaddr[31:29] == 3'b101 |=>
      respValid && paddr == $past(vaddr) - 32'hA000_0000);

  p_hit_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy && tlbValid && tlbStatus == 2'd0 |=>
      respValid && paddr == $past(tlbPaddr));

  p_dirty_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy && tlbValid && tlbStatus == 2'd3 |=> faultStrobe && excCode == 5'd1 && !refill);

  p_refill_r8: assert property (@(posedge clk) disable iff (!rstN)
    refill && faultStrobe |-> excCode == 5'd2 || excCode == 5'd3);

  p_fault_fields_r10: assert property (@(posedge clk) disable iff (!rstN)
    faultStrobe |-> ctxOut[22:4] == badVaddr[31:13] && ctxOut[3:0] == 4'd0 &&
      entryHiOut[31:13] == badVaddr[31:13] && entryHiOut[12:8] == 5'd0);

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(respValid && faultStrobe));

  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    tlbReq |=> !tlbReq);
endmodule

bind vseg_xlate vseg_xlate_chk i_chk (.*);

// File: tb/test_vseg_xlate.sv
module test_vseg_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] vaddr = '0;
  logic        isWrite = 1'b0;
  logic        userMode = 1'b0;
  logic        erlSet = 1'b0;
  logic [8:0]  ctxHiIn = '0;
  logic [7:0]  asidIn = '0;
  logic        tlbValid = 1'b0;
  logic [1:0]  tlbStatus = '0;
  logic [31:0] tlbPaddr = '0;
  logic        tlbReq, tlbWrite, respValid, faultStrobe, refill;
  logic [31:0] tlbVaddr, paddr, badVaddr, ctxOut, entryHiOut;
  logic [4:0]  excCode;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vseg_xlate i_vseg_xlate (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendReq(input logic [31:0] va, input logic wr, input logic um,
                         input logic erl, input logic [8:0] ch, input logic [7:0] asid);
    @(negedge clk);
    vaddr = va; isWrite = wr; userMode = um; erlSet = erl;
    ctxHiIn = ch; asidIn = asid; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    ctxHiIn = ~ch; asidIn = ~asid;
  endtask

  task automatic tlbAnswer(input logic [1:0] st, input logic [31:0] pa);
    tlbStatus = st; tlbPaddr = pa; tlbValid = 1'b1;
    @(negedge clk);
    tlbValid = 1'b0;
  endtask

  task automatic chkFault(input string tag, input logic [4:0] code, input logic rf,
                          input logic [31:0] va, input logic [8:0] ch, input logic [7:0] asid);
    chk({tag, " strobe"}, {31'd0, faultStrobe}, 32'd1);
    chk({tag, " no resp"}, {31'd0, respValid}, 32'd0);
    chk({tag, " code"}, {27'd0, excCode}, {27'd0, code});
    chk({tag, " refill"}, {31'd0, refill}, {31'd0, rf});
    chk({tag, " R10 badVaddr"}, badVaddr, va);
    chk({tag, " R10 ctxOut"}, ctxOut, {ch, va[31:13], 4'b0000});
    chk({tag, " R10 entryHiOut"}, entryHiOut, {va[31:13], 5'b00000, asid});
  endtask

  task automatic chkResp(input string tag, input logic [31:0] pa);
    chk({tag, " resp"}, {31'd0, respValid}, 32'd1);
    chk({tag, " no fault"}, {31'd0, faultStrobe}, 32'd0);
    chk({tag, " paddr"}, paddr, pa);
  endtask

  task automatic tReset();
    chk("R1 respValid", {31'd0, respValid}, 32'd0);
    chk("R1 faultStrobe", {31'd0, faultStrobe}, 32'd0);
    chk("R1 tlbReq", {31'd0, tlbReq}, 32'd0);
  endtask

  task automatic tUserBad();
    sendReq(32'h8000_1234, 1'b0, 1'b1, 1'b0, 9'h155, 8'h3C);
    chkFault("R2 load", 5'd4, 1'b0, 32'h8000_1234, 9'h155, 8'h3C);
    chk("R2 no lookup", {31'd0, tlbReq}, 32'd0);
    sendReq(32'hC000_0000, 1'b1, 1'b1, 1'b1, 9'h0AA, 8'h01);
    chkFault("R2 store", 5'd5, 1'b0, 32'hC000_0000, 9'h0AA, 8'h01);
    @(negedge clk);
    chk("R11 fault pulse", {31'd0, faultStrobe}, 32'd0);
  endtask

  task automatic tKseg01();
    sendReq(32'h8123_4567, 1'b0, 1'b0, 1'b0, 9'd0, 8'd0);
    chkResp("R4 kseg0", 32'h0123_4567);
    sendReq(32'h9FFF_FFFF, 1'b1, 1'b0, 1'b0, 9'd0, 8'd0);
    chkResp("R4 kseg0 top", 32'h1FFF_FFFF);
    sendReq(32'hA000_0000, 1'b0, 1'b0, 1'b0, 9'd0, 8'd0);
    chkResp("R5 kseg1 base", 32'h0000_0000);
    sendReq(32'hBFFF_FFFC, 1'b1, 1'b0, 1'b0, 9'd0, 8'd0);
    chkResp("R5 kseg1 top", 32'h1FFF_FFFC);
    @(negedge clk);
    chk("R11 resp pulse", {31'd0, respValid}, 32'd0);
  endtask

  task automatic tErl();
    sendReq(32'h0000_1000, 1'b0, 1'b0, 1'b1, 9'd0, 8'd0);
    chkResp("R3 erl kernel", 32'h0000_1000);
    chk("R3 erl no lookup", {31'd0, tlbReq}, 32'd0);
    sendReq(32'h7FFF_FFFF, 1'b1, 1'b1, 1'b1, 9'd0, 8'd0);
    chkResp("R3 erl user", 32'h7FFF_FFFF);
  endtask

  task automatic tUsegHit();
    sendReq(32'h0040_2000, 1'b1, 1'b1, 1'b0, 9'h011, 8'h22);
    chk("R3 tlbReq", {31'd0, tlbReq}, 32'd1);
    chk("R3 tlbVaddr", tlbVaddr, 32'h0040_2000);
    chk("R3 tlbWrite", {31'd0, tlbWrite}, 32'd1);
    chk("R3 nothing yet", {30'd0, respValid, faultStrobe}, 32'd0);
    tlbAnswer(2'd0, 32'h1234_5000);
    chkResp("R7 hit", 32'h1234_5000);
    chk("R11 req pulse", {31'd0, tlbReq}, 32'd0);
  endtask

  task automatic tKernelMapped();
    sendReq(32'hC000_4000, 1'b0, 1'b0, 1'b0, 9'h1FF, 8'hA5);
    chk("R6 kseg2 tlbReq", {31'd0, tlbReq}, 32'd1);
    chk("R6 kseg2 tlbVaddr", tlbVaddr, 32'hC000_4000);
    chk("R6 kseg2 tlbWrite", {31'd0, tlbWrite}, 32'd0);
    tlbAnswer(2'd1, 32'd0);
    chkFault("R8 miss load", 5'd2, 1'b1, 32'hC000_4000, 9'h1FF, 8'hA5);

    sendReq(32'hE00F_F000, 1'b1, 1'b0, 1'b0, 9'h0F0, 8'h5A);
    chk("R6 kseg3 tlbReq", {31'd0, tlbReq}, 32'd1);
    tlbAnswer(2'd1, 32'd0);
    chkFault("R8 miss store", 5'd3, 1'b1, 32'hE00F_F000, 9'h0F0, 8'h5A);

    sendReq(32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, 9'h1FF, 8'hFF);
    tlbAnswer(2'd2, 32'd0);
    chkFault("R8 invalid store", 5'd3, 1'b0, 32'hDEAD_BEEF, 9'h1FF, 8'hFF);

    sendReq(32'h0000_3FFF, 1'b0, 1'b1, 1'b0, 9'h100, 8'h80);
    tlbAnswer(2'd2, 32'd0);
    chkFault("R8 invalid load", 5'd2, 1'b0, 32'h0000_3FFF, 9'h100, 8'h80);

    sendReq(32'hF123_6000, 1'b1, 1'b0, 1'b0, 9'h0C3, 8'h07);
    tlbAnswer(2'd3, 32'd0);
    chkFault("R9 dirty", 5'd1, 1'b0, 32'hF123_6000, 9'h0C3, 8'h07);
  endtask

  task automatic tIgnore();
    sendReq(32'hC800_0000, 1'b0, 1'b0, 1'b0, 9'd0, 8'd0);
    // lookup outstanding: a kseg0 request now must be dropped
    vaddr = 32'h8000_0040; userMode = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R11 busy req dropped", {30'd0, respValid, faultStrobe}, 32'd0);
    chk("R11 busy no new lookup", {31'd0, tlbReq}, 32'd0);
    tlbAnswer(2'd0, 32'h0ABC_0000);
    chkResp("R11 original served", 32'h0ABC_0000);
    @(negedge clk);
    // stray verdict while idle
    tlbAnswer(2'd3, 32'h5555_5555);
    chk("R11 stray verdict", {30'd0, respValid, faultStrobe}, 32'd0);
    chk("R11 stray paddr", paddr, 32'h0ABC_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tUserBad();
    tKseg01();
    tErl();
    tUsegHit();
    tKernelMapped();
    tIgnore();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule